// File: doc/BRIEF.md
# Segmented-Address SPI Register Slave

This block is a slave-side register file of 128 bytes reached over a four-wire SPI link (chip select, serial clock, data in, data out). The master reaches a register through a two-step address: one instruction loads an upper address segment, and a second instruction carries the lower four address bits together with the direction and the access size. The data byte follows the second instruction. The stored segment is kept across chip-select frames. A later access to the same segment can therefore consist of the second instruction alone.

The serial clock, chip select and data input are synchronised into the system clock domain. Serial-clock edges are found by oversampling, so the system clock must run several times faster than the serial clock. The link runs in SPI mode 1, most significant bit first. Input data is sampled on the falling edge of the serial clock, and output data changes after the rising edge. The output line is driven only while a read data byte is in progress. A local parallel port gives combinational read access to any register, for use by the surrounding logic.

Top module: `seg_spi_regfile`

## Requirements
- R1: After reset, register 0x21 holds 0x70, register 0x22 holds 0x13, and every other register holds 0x00. The stored segment resets to 0.
- R2: An instruction byte of exactly 0x10 marks the next byte as a segment byte. The low three bits of the segment byte become address bits [6:4], and its upper bits are ignored.
- R3: An instruction byte with bit 7 clear and bits [6:5] = 00 (and not equal to 0x10) is a write. The following byte is stored at address {segment, instruction bits [3:0]}. Instruction bit 4 is not decoded.
- R4: An instruction byte with bit 7 set and bits [6:5] = 00 is a read. In the following byte, the addressed register is shifted out MSB first. The output changes only after a rising serial-clock edge and is held through the next falling edge.
- R5: The stored segment persists across chip-select frames. A frame that contains only a read or write instruction uses the segment stored earlier.
- R6: A rising chip select discards any partly received byte and any pending data phase, and leaves all registers unchanged. The next frame starts by expecting an instruction byte. The stored segment is kept.
- R7: `miso_oe` is high only during the data byte of a read while chip select is low. While `miso_oe` is low, `miso` is high impedance.
- R8: An instruction byte whose bits [6:5] are not 00 selects no register. Its following byte is consumed, no register changes, and `miso_oe` stays low.
- R9: Several transactions may follow one another within one frame, for example a segment load, then a write, then a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used for oversampling the serial signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| csb | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the master, idle low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial read data; high impedance when not enabled |
| miso_oe | output | 1 | High while `miso` is driven |
| loc_addr | input | 7 | Local read address |
| loc_data | output | 8 | Contents of the register at `loc_addr` |

## Verification
The bound checker watches every cycle for three things. The output enable must stay low while chip select is high, and it may rise only when chip select was low at the synchroniser input. The read line must stay still while the serial clock is low. The register contents must stay frozen while the slave is deselected. The following behaviours are shown only by the bench's scenarios, which read back through the serial link and the local port: correct segment and address decoding, the retained segment across frames, the discarding of aborted bytes, and the skipping of bytes with an unsupported size code.

// File: rtl/seg_spi_regfile.sv
module seg_spi_regfile #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic [ADDR_W-1:0] loc_addr,
  output logic [DATA_W-1:0] loc_data
);
  localparam int LO_W  = 4;
  localparam int SEG_W = ADDR_W - LO_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] SEG_CMD  = DATA_W'(8'h10);

  typedef enum logic [2:0] {ST_INSTR, ST_SEG, ST_WDATA, ST_RDATA, ST_SKIP} phase_t;

  function automatic logic [DATA_W-1:0] reg_default(int unsigned a);
    case (a)
      32'h21:  return DATA_W'(8'h70);
      32'h22:  return DATA_W'(8'h13);
      default: return '0;
    endcase
  endfunction

  logic [SYNC_N-1:0] sclk_sy, csb_sy, mosi_sy;
  logic              sclk_d;
  logic              sclk_s, csb_s, mosi_s, rise, fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0;
      csb_sy  <= '1;
      mosi_sy <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_N-2:0], sclk};
      csb_sy  <= {csb_sy[SYNC_N-2:0], csb};
      mosi_sy <= {mosi_sy[SYNC_N-2:0], mosi};
      sclk_d  <= sclk_sy[SYNC_N-1];
    end

  assign sclk_s = sclk_sy[SYNC_N-1];
  assign csb_s  = csb_sy[SYNC_N-1];
  assign mosi_s = mosi_sy[SYNC_N-1];
  assign rise   = sclk_s & ~sclk_d & ~csb_s;
  assign fall   = ~sclk_s & sclk_d & ~csb_s;

  phase_t            phase;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;
  logic [SEG_W-1:0]  seg;
  logic [ADDR_W-1:0] addr;
  logic              miso_q;
  logic [DATA_W-1:0] regs [DEPTH];

  logic [DATA_W-1:0] nxt_byte;
  logic              byte_done, wr_en;
  logic [DATA_W-1:0] rd_word;

  assign nxt_byte  = {shreg[DATA_W-2:0], mosi_s};
  assign byte_done = fall && bitcnt == LAST_BIT;
  assign wr_en     = byte_done && phase == ST_WDATA;
  assign rd_word   = regs[addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase  <= ST_INSTR;
      bitcnt <= '0;
      shreg  <= '0;
      seg    <= '0;
      addr   <= '0;
      miso_q <= 1'b0;
    end else if (csb_s) begin
      phase  <= ST_INSTR;
      bitcnt <= '0;
    end else begin
      if (rise && phase == ST_RDATA)
        miso_q <= rd_word[LAST_BIT - bitcnt];
      if (fall) begin
        shreg  <= nxt_byte;
        bitcnt <= bitcnt + 1'b1;
      end
      if (byte_done) begin
        bitcnt <= '0;
        case (phase)
          ST_INSTR: begin
            addr <= {seg, nxt_byte[LO_W-1:0]};
            if (nxt_byte == SEG_CMD)
              phase <= ST_SEG;
            else if (nxt_byte[DATA_W-2 -: 2] != 2'b00)
              phase <= ST_SKIP;
            else if (nxt_byte[DATA_W-1])
              phase <= ST_RDATA;
            else
              phase <= ST_WDATA;
          end
          ST_SEG: begin
            seg   <= nxt_byte[SEG_W-1:0];
            phase <= ST_INSTR;
          end
          default: phase <= ST_INSTR;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= reg_default(i);
    end else if (wr_en) begin
      regs[addr] <= nxt_byte;
    end

  assign miso_oe  = (phase == ST_RDATA) && !csb_s;
  assign miso     = miso_oe ? miso_q : 1'bz;
  assign loc_data = regs[loc_addr];
endmodule

// File: rtl/seg_spi_regfile_chk.sv
module seg_spi_regfile_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csb,
  input logic              sclk,
  input logic              miso,
  input logic              miso_oe,
  input logic [ADDR_W-1:0] loc_addr,
  input logic [DATA_W-1:0] loc_data
);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csb && $past(csb) && $past(csb, 2) && $past(csb, 3)) |-> !miso_oe);

  // R7
  oe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !$past(csb, 2));

  // R4
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && !sclk && !$past(sclk) && !$past(sclk, 2)
     && !$past(sclk, 3) && !$past(sclk, 4)) |-> $stable(miso));

  // R6
  regs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(csb) && $past(csb, 2) && $past(csb, 3) && $stable(loc_addr))
    |-> $stable(loc_data));
endmodule

bind seg_spi_regfile seg_spi_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csb(csb), .sclk(sclk), .miso(miso),
  .miso_oe(miso_oe), .loc_addr(loc_addr), .loc_data(loc_data)
);

// File: tb/seg_spi_regfile_bench.sv
module seg_spi_regfile_bench;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csb = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  logic [6:0] loc_addr = '0;
  logic [7:0] loc_data;

  int checks = 0, fails = 0;
  bit done = 0, oe_seen = 0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  seg_spi_regfile u_seg_spi_regfile (
    .clk(clk), .rst_n(rst_n), .csb(csb), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .loc_addr(loc_addr), .loc_data(loc_data)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sclk = 1'b1;
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      if (miso_oe) oe_seen = 1;
      sclk = 1'b0;
      wait_clk(HALF);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    logic [7:0] rx;
    shift_bits(b, 8, rx);
  endtask

  task automatic rd_byte(input logic [7:0] exp, input string tag);
    logic [7:0] rx;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    shift_bits(8'h00, 8, rx);
    got_q.push_back(rx);
  endtask

  task automatic sel;
    @(negedge clk);
    csb = 1'b0;
    wait_clk(4);
  endtask

  task automatic desel;
    wait_clk(4);
    csb = 1'b1;
    wait_clk(8);
  endtask

  task automatic local_chk(input logic [6:0] a, input logic [7:0] exp, input string tag);
    loc_addr = a;
    wait_clk(1);
    check(loc_data === exp, tag, loc_data, exp);
  endtask

  initial begin : monitor
    forever begin
      wait (got_q.size() != 0);
      check(got_q[0] === exp_q[0], tag_q[0], got_q[0], exp_q[0]);
      void'(got_q.pop_front());
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    logic [7:0] rx;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);

    local_chk(7'h21, 8'h70, "R1 reset 0x21");
    local_chk(7'h22, 8'h13, "R1 reset 0x22");
    local_chk(7'h00, 8'h00, "R1 reset 0x00");
    local_chk(7'h7f, 8'h00, "R1 reset 0x7f");
    check(miso_oe === 1'b0 && miso === 1'bz, "R7 idle after reset", {6'b0, miso_oe, miso}, 8'h00);

    // R9 segment load then read in one frame; R4 shifted data
    sel; wr_byte(8'h10); wr_byte(8'h02); wr_byte(8'h82);
    oe_seen = 0; rd_byte(8'h13, "R4 read 0x22"); desel;
    check(oe_seen, "R7 oe during read", {7'b0, oe_seen}, 8'h01);
    check(miso_oe === 1'b0 && miso === 1'bz, "R7 released after frame", {6'b0, miso_oe, miso}, 8'h00);

    // R5 read with transaction 2 only
    sel; wr_byte(8'h81); rd_byte(8'h70, "R5 retained segment read 0x21"); desel;

    // R3 write, R9 write then read back in same frame
    sel; wr_byte(8'h10); wr_byte(8'h05); wr_byte(8'h03); wr_byte(8'hA5);
    wr_byte(8'h04); wr_byte(8'h3C); wr_byte(8'h84); rd_byte(8'h3C, "R9 readback 0x54"); desel;
    local_chk(7'h53, 8'hA5, "R3 write 0x53");
    local_chk(7'h54, 8'h3C, "R9 write 0x54");

    // R3 bit 4 not decoded; R5 write with transaction 2 only
    sel; wr_byte(8'h16); wr_byte(8'h77); desel;
    local_chk(7'h56, 8'h77, "R5 retained segment write 0x56");
    sel; wr_byte(8'h96); rd_byte(8'h77, "R3 bit4 ignored read 0x56"); desel;

    // R2 segment upper bits ignored, top segment
    sel; wr_byte(8'h10); wr_byte(8'hFF); wr_byte(8'h0F); wr_byte(8'h5A); desel;
    local_chk(7'h7f, 8'h5A, "R2 segment 7 write");
    local_chk(7'h0f, 8'h00, "R2 no alias at 0x0f");

    // R8 unsupported sizes
    sel; wr_byte(8'h10); wr_byte(8'h02); wr_byte(8'h21); wr_byte(8'hFF);
    oe_seen = 0; wr_byte(8'hC1); wr_byte(8'h00);
    check(!oe_seen, "R8 no drive on odd size", {7'b0, oe_seen}, 8'h00);
    wr_byte(8'h82); rd_byte(8'h13, "R8 stream resumes"); desel;
    local_chk(7'h21, 8'h70, "R8 0x21 unchanged");

    // R6 partial segment byte aborted, segment kept
    sel; wr_byte(8'h10); shift_bits(8'h06, 4, rx); desel;
    sel; wr_byte(8'h81); rd_byte(8'h70, "R6 segment kept after abort"); desel;

    // R6 partial write data aborted
    sel; wr_byte(8'h01); shift_bits(8'hEE, 5, rx); desel;
    local_chk(7'h21, 8'h70, "R6 aborted write no effect");
    sel; wr_byte(8'h82); rd_byte(8'h13, "R6 instruction expected after abort"); desel;

    wait (got_q.size() == 0);
    wait_clk(2);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule